// File: doc/BRIEF.md
# Requester Tag Association Tracker

This block sits on the user side of a PCIe requester. Every Non-Posted request that the user logic sends is recorded as a descriptor in an in-order pending queue. The requester allocates a tag for each request some cycles later and returns it on one of two tag ports. Each port has a valid that is high for a single cycle. Tags come back in the order the requests were sent. New requests may go out while earlier tags are still outstanding. The tracker pops the queue as tags arrive and emits each tag together with its descriptor. It also writes the descriptor into a tag-indexed table, so that completion logic can look it up by tag.

The free-tag count reported by the requester lags. It does not yet include tags consumed by requests sent during roughly the last eight cycles. The tracker keeps a short history of its own sends and subtracts them from the reported count, with a floor of zero. It issues a request only when this adjusted count is non-zero and the pending queue has room.

Top module: `rq_tag_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `tag_free_adj` is 0, `pair_vld0` and `pair_vld1` are 0, and `err_orphan` is 0.
- R2: `tag_free_adj` in cycle k+1 equals `tag_free_raw` of cycle k minus the number of cycles among k, k-1, ..., k-LAG+1 (LAG=8) in which `req_fire` was high.
- R3: When that difference would be negative, `tag_free_adj` is 0.
- R4: `req_fire` is high exactly when `req_want` is high, `tag_free_adj` is non-zero and the pending queue holds fewer than QDEPTH entries. A fired cycle enqueues `req_desc`.
- R5: Descriptors are paired with returned tags strictly in the order in which they were issued, including when further requests are issued while tags are outstanding.
- R6: When both tag valids are high in one cycle, `pair_*0` carries `tag0` with the older descriptor and `pair_*1` carries `tag1` with the next one. `pair_vld1` is never high without `pair_vld0`.
- R7: A valid on tag port 1 alone is paired with the oldest pending descriptor and reported on `pair_*0`.
- R8: The pair outputs are registered. They appear in the cycle after the tag valids and stay high for one cycle per tag.
- R9: A tag that arrives with no pending descriptor produces no pair and sets `err_orphan`, which stays high until reset.
- R10: With QDEPTH (16) descriptors pending, `req_fire` stays low regardless of `req_want`.
- R11: `lk_desc` in cycle k+1 is the descriptor most recently paired with tag `lk_tag` of cycle k. A pair written in cycle k is not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_want | input | 1 | User has a Non-Posted request ready |
| req_desc | input | DESC_W | Descriptor of that request |
| req_fire | output | 1 | Request is issued this cycle |
| tag_free_raw | input | CNT_W | Lagging free-tag count from the requester |
| tag_free_adj | output | CNT_W | Free-tag count corrected for recent sends |
| tag_vld0 | input | 1 | Tag port 0 valid, one cycle per tag |
| tag0 | input | TAG_W | Tag port 0 value |
| tag_vld1 | input | 1 | Tag port 1 valid |
| tag1 | input | TAG_W | Tag port 1 value |
| pair_vld0 | output | 1 | First pair valid |
| pair_tag0 | output | TAG_W | First pair tag |
| pair_desc0 | output | DESC_W | First pair descriptor |
| pair_vld1 | output | 1 | Second pair valid |
| pair_tag1 | output | TAG_W | Second pair tag |
| pair_desc1 | output | DESC_W | Second pair descriptor |
| err_orphan | output | 1 | Sticky flag for a tag with nothing pending |
| lk_tag | input | TAG_W | Table lookup address |
| lk_desc | output | DESC_W | Descriptor stored for `lk_tag`, one cycle later |

## Verification
The assertions assume that the tag valids are single-cycle pulses. They also assume that the requester never reports more free tags than the counter width can hold. The same tag is never presented on both ports in one cycle, and a lookup does not target a tag being written in that cycle. The stimulus uses distinct, increasing tag numbers and drives every valid for exactly one cycle. It reads the lookup table only at least two cycles after the last write to the tag in question. One deliberate orphan tag is injected while the queue is empty, after all real tags have drained.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  // Modular pointer advance for a ring of arbitrary depth.
  function automatic int unsigned ring_add(input int unsigned p, input int unsigned k,
                                           input int unsigned depth);
    int unsigned s;
    s = p + k;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rtt_free_est.sv
module rtt_free_est #(
  parameter int CNT_W = 4,
  parameter int LAG   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sent,
  input  logic [CNT_W-1:0] raw,
  output logic [CNT_W-1:0] adj
);
  localparam int RW = $clog2(LAG + 1);
  localparam int EW = ((CNT_W > RW) ? CNT_W : RW) + 1;

  logic [LAG-1:0] hist, hist_nx;
  logic [RW-1:0]  recent;
  logic [EW-1:0]  raw_e, rec_e;

  always_comb begin
    hist_nx = {hist[LAG-2:0], sent};
    recent  = '0;
    for (int i = 0; i < LAG; i++) recent = recent + RW'(hist_nx[i]);
    raw_e = EW'(raw);
    rec_e = EW'(recent);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      adj  <= '0;
    end else begin
      hist <= hist_nx;
      adj  <= (raw_e > rec_e) ? CNT_W'(raw_e - rec_e) : '0;
    end
  end
endmodule

// File: rtl/rtt_pend_fifo.sv
module rtt_pend_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CQ_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic [1:0]      pop_n,
  output logic [DW-1:0]   head0,
  output logic [DW-1:0]   head1,
  output logic [CQ_W-1:0] count,
  output logic            full
);
  import rtt_pkg::*;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt;

  always_comb begin
    rd_nxt = PTR_W'(ring_add(int'(rd_ptr), 1, DEPTH));
    head0  = mem[rd_ptr];
    head1  = mem[rd_nxt];
    full   = (count == CQ_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
      rd_ptr <= PTR_W'(ring_add(int'(rd_ptr), int'(pop_n), DEPTH));
      count  <= count + CQ_W'(push) - CQ_W'(pop_n);
    end
  end
endmodule

// File: rtl/rtt_tag_lut.sv
module rtt_tag_lut #(
  parameter int TAG_W = 8,
  parameter int DW    = 16,
  localparam int ENTRIES = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             we0,
  input  logic [TAG_W-1:0] wa0,
  input  logic [DW-1:0]    wd0,
  input  logic             we1,
  input  logic [TAG_W-1:0] wa1,
  input  logic [DW-1:0]    wd1,
  input  logic [TAG_W-1:0] ra,
  output logic [DW-1:0]    rd
);
  logic [DW-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (we0) tbl[wa0] <= wd0;
    if (we1) tbl[wa1] <= wd1;
    rd <= tbl[ra];
  end
endmodule

// File: rtl/rq_tag_tracker.sv
module rq_tag_tracker #(
  parameter int TAG_W  = 8,
  parameter int DESC_W = 16,
  parameter int QDEPTH = 16,
  parameter int CNT_W  = 4,
  parameter int LAG    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_want,
  input  logic [DESC_W-1:0] req_desc,
  output logic              req_fire,
  input  logic [CNT_W-1:0]  tag_free_raw,
  output logic [CNT_W-1:0]  tag_free_adj,
  input  logic              tag_vld0,
  input  logic [TAG_W-1:0]  tag0,
  input  logic              tag_vld1,
  input  logic [TAG_W-1:0]  tag1,
  output logic              pair_vld0,
  output logic [TAG_W-1:0]  pair_tag0,
  output logic [DESC_W-1:0] pair_desc0,
  output logic              pair_vld1,
  output logic [TAG_W-1:0]  pair_tag1,
  output logic [DESC_W-1:0] pair_desc1,
  output logic              err_orphan,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [DESC_W-1:0] lk_desc
);
  localparam int CQ_W = $clog2(QDEPTH + 1);

  logic [CQ_W-1:0]   q_count;
  logic              q_full;
  logic [DESC_W-1:0] head0, head1;
  logic [1:0]        n_in, pop_n;
  logic              orphan;
  logic [TAG_W-1:0]  tag_sel0;

  rtt_free_est #(.CNT_W(CNT_W), .LAG(LAG)) u_est (
    .clk(clk), .rst(rst), .sent(req_fire), .raw(tag_free_raw), .adj(tag_free_adj)
  );

  rtt_pend_fifo #(.DW(DESC_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(req_fire), .push_data(req_desc), .pop_n(pop_n),
    .head0(head0), .head1(head1), .count(q_count), .full(q_full)
  );

  always_comb begin
    req_fire = req_want && (tag_free_adj != '0) && !q_full;
    n_in     = {1'b0, tag_vld0} + {1'b0, tag_vld1};
    orphan   = (CQ_W'(n_in) > q_count);
    pop_n    = orphan ? q_count[1:0] : n_in;
    tag_sel0 = tag_vld0 ? tag0 : tag1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_vld0  <= 1'b0;
      pair_vld1  <= 1'b0;
      err_orphan <= 1'b0;
    end else begin
      pair_vld0  <= (pop_n != 2'd0);
      pair_vld1  <= (pop_n == 2'd2);
      err_orphan <= err_orphan | orphan;
    end
  end

  always_ff @(posedge clk) begin
    pair_tag0  <= tag_sel0;
    pair_desc0 <= head0;
    pair_tag1  <= tag1;
    pair_desc1 <= head1;
  end

  rtt_tag_lut #(.TAG_W(TAG_W), .DW(DESC_W)) u_lut (
    .clk(clk),
    .we0(pop_n != 2'd0), .wa0(tag_sel0), .wd0(head0),
    .we1(pop_n == 2'd2), .wa1(tag1),     .wd1(head1),
    .ra(lk_tag), .rd(lk_desc)
  );
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int QDEPTH = 16,
  parameter int CNT_W  = 4,
  localparam int CQ_W  = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_want,
  input logic             req_fire,
  input logic [CNT_W-1:0] tag_free_raw,
  input logic [CNT_W-1:0] tag_free_adj,
  input logic             tag_vld0,
  input logic             tag_vld1,
  input logic             pair_vld0,
  input logic             pair_vld1,
  input logic             err_orphan,
  input logic [CQ_W-1:0]  q_count
);
  AST_FIRE_GATED: assert property (@(posedge clk) disable iff (rst)
    req_fire |-> (req_want && tag_free_adj != '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_count <= CQ_W'(QDEPTH)); // R10
  AST_ADJ_BELOW_RAW: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> tag_free_adj < $past(tag_free_raw) || tag_free_adj == '0); // R2
  AST_PAIR_AFTER_TAG: assert property (@(posedge clk) disable iff (rst)
    pair_vld0 |-> $past(tag_vld0 || tag_vld1)); // R8
  AST_PAIR1_NEEDS_PAIR0: assert property (@(posedge clk) disable iff (rst)
    pair_vld1 |-> pair_vld0); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_orphan |=> err_orphan); // R9
endmodule

bind rq_tag_tracker rtt_checker #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_want(req_want), .req_fire(req_fire),
  .tag_free_raw(tag_free_raw), .tag_free_adj(tag_free_adj),
  .tag_vld0(tag_vld0), .tag_vld1(tag_vld1),
  .pair_vld0(pair_vld0), .pair_vld1(pair_vld1),
  .err_orphan(err_orphan), .q_count(q_count)
);

// File: tb/test_rq_tag_tracker.sv
module test_rq_tag_tracker;
  localparam int TW = 8, DW = 16, QD = 16, CW = 4, LG = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_want = 1'b0, req_fire;
  logic [DW-1:0] req_desc = '0;
  logic [CW-1:0] tag_free_raw = '0, tag_free_adj;
  logic tag_vld0 = 1'b0, tag_vld1 = 1'b0;
  logic [TW-1:0] tag0 = '0, tag1 = '0, lk_tag = '0;
  logic pair_vld0, pair_vld1, err_orphan;
  logic [TW-1:0] pair_tag0, pair_tag1;
  logic [DW-1:0] pair_desc0, pair_desc1, lk_desc;

  always #2 clk = ~clk;

  rq_tag_tracker #(.TAG_W(TW), .DESC_W(DW), .QDEPTH(QD), .CNT_W(CW), .LAG(LG)) i_rq_tag_tracker (
    .clk(clk), .rst(rst), .req_want(req_want), .req_desc(req_desc), .req_fire(req_fire),
    .tag_free_raw(tag_free_raw), .tag_free_adj(tag_free_adj),
    .tag_vld0(tag_vld0), .tag0(tag0), .tag_vld1(tag_vld1), .tag1(tag1),
    .pair_vld0(pair_vld0), .pair_tag0(pair_tag0), .pair_desc0(pair_desc0),
    .pair_vld1(pair_vld1), .pair_tag1(pair_tag1), .pair_desc1(pair_desc1),
    .err_orphan(err_orphan), .lk_tag(lk_tag), .lk_desc(lk_desc)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int tnext = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard model state
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] lutm[int];
  bit fh[LG];
  int exp_adj = 0, exp_np = 0;
  bit exp_clamp = 0, exp_err = 0, exp_p1only = 0, lk_v = 0;
  int exp_t0 = 0, exp_t1 = 0;
  logic [DW-1:0] lk_exp = '0;

  // Monitor: compares outputs each cycle against the model, then advances it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        exp_q.delete();
        foreach (fh[i]) fh[i] = 0;
        exp_adj = 0; exp_np = 0; exp_err = 0; exp_clamp = 0; lk_v = 0;
      end else begin
        int sz_before, nv, recent;
        bit fire_exp;
        logic [DW-1:0] d;
        chk(int'(tag_free_adj) == exp_adj, exp_clamp ? "R3 clamp" : "R2 adjust",
            int'(tag_free_adj), exp_adj);
        chk(pair_vld0 == (exp_np >= 1), exp_p1only ? "R7 pair_vld0" : "R8 pair_vld0",
            int'(pair_vld0), int'(exp_np >= 1));
        chk(pair_vld1 == (exp_np == 2), "R6 pair_vld1", int'(pair_vld1), int'(exp_np == 2));
        if (exp_np >= 1) begin
          d = exp_q.pop_front();
          chk(pair_desc0 == d, "R5 pair_desc0", int'(pair_desc0), int'(d));
          chk(int'(pair_tag0) == exp_t0, exp_p1only ? "R7 pair_tag0" : "R5 pair_tag0",
              int'(pair_tag0), exp_t0);
          lutm[exp_t0] = d;
        end
        if (exp_np == 2) begin
          d = exp_q.pop_front();
          chk(pair_desc1 == d, "R6 pair_desc1", int'(pair_desc1), int'(d));
          chk(int'(pair_tag1) == exp_t1, "R6 pair_tag1", int'(pair_tag1), exp_t1);
          lutm[exp_t1] = d;
        end
        chk(err_orphan == exp_err, "R9 err_orphan", int'(err_orphan), int'(exp_err));
        if (lk_v) chk(lk_desc == lk_exp, "R11 lookup", int'(lk_desc), int'(lk_exp));
        sz_before = exp_q.size();
        fire_exp = req_want && (exp_adj != 0) && (sz_before < QD);
        chk(req_fire == fire_exp, (sz_before >= QD) ? "R10 full" : "R4 fire",
            int'(req_fire), int'(fire_exp));
        if (fire_exp) exp_q.push_back(req_desc);
        nv = int'(tag_vld0) + int'(tag_vld1);
        if (nv > sz_before) exp_err = 1;
        exp_np = (nv > sz_before) ? sz_before : nv;
        exp_t0 = tag_vld0 ? int'(tag0) : int'(tag1);
        exp_t1 = int'(tag1);
        exp_p1only = tag_vld1 && !tag_vld0;
        for (int i = LG - 1; i > 0; i--) fh[i] = fh[i-1];
        fh[0] = fire_exp;
        recent = 0;
        foreach (fh[i]) recent += int'(fh[i]);
        exp_clamp = recent > int'(tag_free_raw);
        exp_adj = exp_clamp ? 0 : int'(tag_free_raw) - recent;
        lk_v = lutm.exists(int'(lk_tag));
        if (lk_v) lk_exp = lutm[int'(lk_tag)];
      end
    end
  end

  // Driver tasks
  task automatic issue_n(input int n, input logic [DW-1:0] base);
    int sent = 0;
    int guard = 0;
    while (sent < n && guard < 200) begin
      @(negedge clk);
      req_want = 1'b1;
      req_desc = base + DW'(sent);
      #1;
      if (req_fire) sent++;
      guard++;
    end
    @(negedge clk);
    req_want = 1'b0;
  endtask

  task automatic give_tags(input bit v0, input bit v1);
    @(negedge clk);
    tag_vld0 = v0; tag0 = TW'(tnext);
    if (v0) tnext++;
    tag_vld1 = v1; tag1 = TW'(tnext);
    if (v1) tnext++;
    @(negedge clk);
    tag_vld0 = 1'b0; tag_vld1 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int n;
    idle(2);
    n = exp_q.size();
    while (n >= 2) begin give_tags(1, 1); n -= 2; end
    if (n == 1) give_tags(1, 0);
    idle(2);
  endtask

  task automatic lookup_range(input int lo, input int hi);
    for (int t = lo; t <= hi; t++) begin
      @(negedge clk);
      lk_tag = TW'(t);
    end
    idle(2);
  endtask

  initial begin
    tag_free_raw = 4'd15;
    repeat (3) @(posedge clk);
    #1;
    chk(tag_free_adj == 0, "R1 adj in reset", int'(tag_free_adj), 0);
    chk(pair_vld0 == 0 && pair_vld1 == 0, "R1 pairs in reset", int'(pair_vld0), 0);
    chk(err_orphan == 0, "R1 err in reset", int'(err_orphan), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(tag_free_adj == 0, "R1 adj after reset", int'(tag_free_adj), 0);

    // R5/R8: in-order singles, overlapping with new issue
    issue_n(4, 16'h0100);
    idle(3);
    give_tags(1, 0);
    give_tags(1, 0);
    issue_n(2, 16'h0200);
    give_tags(1, 1);              // R6 dual return
    give_tags(0, 1);              // R7 port 1 alone
    give_tags(1, 0);
    drain();
    lookup_range(1, 6);           // R11

    // R3: recent sends exceed a shrinking raw count
    issue_n(3, 16'h0300);
    tag_free_raw = 4'd1;
    idle(4);
    tag_free_raw = 4'd2;
    issue_n(4, 16'h0380);         // R2 throttled by history
    tag_free_raw = 4'd15;
    drain();

    // R10: fill the queue, keep asking
    issue_n(QD, 16'h0400);
    @(negedge clk);
    req_want = 1'b1; req_desc = 16'hdead;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(req_fire == 1'b0, "R10 blocked when full", int'(req_fire), 0);
      @(negedge clk);
    end
    req_want = 1'b0;
    drain();
    lookup_range(tnext - 6, tnext - 1);

    // R9: orphan tag with an empty queue
    give_tags(1, 0);
    idle(6);
    #1;
    chk(err_orphan == 1'b1, "R9 sticky orphan", int'(err_orphan), 1);
    issue_n(2, 16'h0500);
    drain();
    #1;
    chk(err_orphan == 1'b1, "R9 still set", int'(err_orphan), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule